// File: doc/BRIEF.md
# Shadowed Configuration Reload and Interrupt Unit

This block keeps two copies of a small set of display configuration words. Software writes only the staging (shadow) copy. The display pipeline sees only the live (active) copy. Software moves the staging copy into the live copy in one of two ways: at once, or at the next vertical-blanking strobe. A staged update therefore never reaches the pipeline in the middle of a frame unless software asks for that.

The unit also collects four event sources into one sticky status register: a line-position match, a FIFO underrun, a transfer error, and the completion of a configuration reload. Each status bit has its own enable bit, and the single interrupt output is asserted while any enabled status bit is set. To acknowledge events, software reads the status register and writes the same value to a write-one-to-clear register.

Access is through a simple word-addressed port. A write happens on the clock edge when `bus_wr` is high. Read data is a combinational function of `bus_addr`. Reset is synchronous and active high.

Top module: `cfg_reload_irq_unit`

## Requirements
- R1: After reset the live words, the staging words, the enable register, the status register and the pending reload request are all zero, and `irq` is low.
- R2: A write to staging word i, at address 4+i, changes only that staging word, which reads back at the same address. The live copy on `active_cfg` stays unchanged until a transfer takes place.
- R3: Writing the reload register (address 0) with bit 0 set copies every staging word into the live copy on the clock edge that accepts the write. Bit 0 always reads back as 0.
- R4: Writing the reload register with bit 1 set and bit 0 clear sets a pending request, which reads back as bit 1 of address 0. The next vertical-blanking strobe seen while the request is pending copies staging to live and clears the request. A strobe that arrives in the same cycle as the write does not consume that write. A strobe with no pending request copies nothing.
- R5: The immediate request has priority. Writing bit 0 and bit 1 together, or writing bit 0 while a deferred request is pending, performs the immediate transfer and leaves no pending request.
- R6: Every transfer, whether immediate or deferred, sets status bit 3 (reload done) on the same edge that updates the live copy.
- R7: A one-cycle pulse on `line_evt`, `underrun_evt` or `xfer_err_evt` sets status bit 0, 1 or 2 respectively, even when that bit's enable is 0. Status reads at address 2, and status bits stay set until they are cleared.
- R8: Writing a mask to the clear register (address 3) clears the status bits where the mask is 1 and leaves the others untouched. Writing back a value just read from status acknowledges exactly those events. Address 3 reads as 0.
- R9: When an event and a clear for the same status bit occur in the same cycle, the bit remains set.
- R10: The enable register (address 1, bits 3..0, same positions as status) reads back as written. `irq` is high exactly when some status bit and its enable bit are both 1.
- R11: Writes to addresses above 4+NUM_CFG-1 change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| vblank_stb | input | 1 | One-cycle vertical-blanking strobe |
| line_evt | input | 1 | Line-position match pulse |
| underrun_evt | input | 1 | FIFO underrun pulse |
| xfer_err_evt | input | 1 | Transfer error pulse |
| active_cfg | output | NUM_CFG*DATA_W | Live configuration words, word i at bits [i*DATA_W +: DATA_W] |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
The bench targets the collisions. A deferred request written in the same cycle as a blanking strobe must stay pending; a design that consumes it would transfer one frame early and lose the later strobe. Immediate and deferred bits written together must leave nothing pending; a design that keeps the deferred bit would do a second, unwanted transfer at the next blanking. An event that coincides with a clear of the same bit must survive; a design that gives the clear priority would drop an interrupt. Masked events must still be recorded, staging writes must not leak into the live copy, and unmapped writes must have no effect. Each of these is checked through the live outputs and the read port.

// File: rtl/cfg_reload_pkg.sv
package cfg_reload_pkg;

    localparam int NUM_EV     = 4;
    localparam int A_RELOAD   = 0;
    localparam int A_IRQ_EN   = 1;
    localparam int A_IRQ_STAT = 2;
    localparam int A_IRQ_CLR  = 3;
    localparam int A_CFG_BASE = 4;

    typedef enum int {
        EV_LINE     = 0,
        EV_UNDERRUN = 1,
        EV_XFER_ERR = 2,
        EV_RELOAD   = 3
    } ev_idx_e;

    typedef struct packed {
        logic reload;
        logic irq_en;
        logic irq_clr;
        logic cfg;
    } wr_sel_t;

    typedef struct packed {
        logic at_vblank;
        logic now;
    } reload_req_t;

    function automatic wr_sel_t decode_sel(input int unsigned addr, input int unsigned ncfg);
        wr_sel_t s;
        s.reload  = (addr == A_RELOAD);
        s.irq_en  = (addr == A_IRQ_EN);
        s.irq_clr = (addr == A_IRQ_CLR);
        s.cfg     = (addr >= A_CFG_BASE) && (addr < A_CFG_BASE + ncfg);
        return s;
    endfunction

endpackage

// File: rtl/reload_seq.sv
module reload_seq
    import cfg_reload_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_wr,
    input  reload_req_t req,
    input  logic        vblank,
    output logic        xfer,
    output logic        pending
);

    logic take_now;
    logic take_late;

    always_comb begin
        take_now  = req_wr && req.now;
        take_late = req_wr && req.at_vblank && !req.now;
        xfer      = take_now || (vblank && pending);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (take_now) begin
            pending <= 1'b0;
        end else if (take_late) begin
            pending <= 1'b1;
        end else if (vblank) begin
            pending <= 1'b0;
        end
    end

    AST_PEND_DROP: assert property (@(posedge clk) disable iff (rst)
        (pending && vblank && !req_wr) |=> !pending); // R4
    AST_LATE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (take_late && vblank) |=> pending); // R4
    AST_NOW_WINS: assert property (@(posedge clk) disable iff (rst)
        take_now |=> !pending); // R5

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
    parameter int DATA_W  = 32,
    parameter int NUM_CFG = 4,
    localparam int IDX_W  = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      xfer,
    output logic [NUM_CFG*DATA_W-1:0] shadow,
    output logic [NUM_CFG*DATA_W-1:0] active
);

    for (genvar i = 0; i < NUM_CFG; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow[i*DATA_W +: DATA_W] <= '0;
                active[i*DATA_W +: DATA_W] <= '0;
            end else begin
                if (wr_en && (wr_idx == IDX_W'(i))) begin
                    shadow[i*DATA_W +: DATA_W] <= wr_data;
                end
                if (xfer) begin
                    active[i*DATA_W +: DATA_W] <= shadow[i*DATA_W +: DATA_W];
                end
            end
        end
    end

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(active)); // R2
    AST_ACTIVE_LOAD: assert property (@(posedge clk) disable iff (rst)
        xfer |=> (active == $past(shadow))); // R3

endmodule

// File: rtl/irq_gather.sv
module irq_gather #(
    parameter int NEV = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en_we,
    input  logic [NEV-1:0] en_wdata,
    input  logic           clr_we,
    input  logic [NEV-1:0] clr_mask,
    input  logic [NEV-1:0] events,
    output logic [NEV-1:0] status,
    output logic [NEV-1:0] enable,
    output logic           irq
);

    logic [NEV-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_we ? clr_mask : '0;
        irq     = |(status & enable);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~clr_eff) | events;
            if (en_we) begin
                enable <= en_wdata;
            end
        end
    end

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        (events != '0) |=> ((status & $past(events)) == $past(events))); // R9
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (clr_we && ((clr_mask & events) == '0)) |=> ((status & $past(clr_mask)) == '0)); // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!clr_we) |=> ((status & $past(status)) == $past(status))); // R7

endmodule

// File: rtl/cfg_reload_irq_unit.sv
module cfg_reload_irq_unit
    import cfg_reload_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_CFG = 4,
    parameter int ADDR_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic                      vblank_stb,
    input  logic                      line_evt,
    input  logic                      underrun_evt,
    input  logic                      xfer_err_evt,
    output logic [NUM_CFG*DATA_W-1:0] active_cfg,
    output logic                      irq
);

    localparam int IDX_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;

    wr_sel_t                   sel;
    wr_sel_t                   wsel;
    reload_req_t               req;
    logic [IDX_W-1:0]          cfg_idx;
    logic                      xfer;
    logic                      pending;
    logic [NUM_CFG*DATA_W-1:0] shadow;
    logic [NUM_EV-1:0]         events;
    logic [NUM_EV-1:0]         status;
    logic [NUM_EV-1:0]         enable;

    always_comb begin
        sel     = decode_sel(int'(bus_addr), NUM_CFG);
        wsel    = bus_wr ? sel : '0;
        req     = reload_req_t'(bus_wdata[1:0]);
        cfg_idx = IDX_W'(int'(bus_addr) - A_CFG_BASE);
        events  = '0;
        events[EV_LINE]     = line_evt;
        events[EV_UNDERRUN] = underrun_evt;
        events[EV_XFER_ERR] = xfer_err_evt;
        events[EV_RELOAD]   = xfer;
    end

    reload_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .req_wr  (wsel.reload),
        .req     (req),
        .vblank  (vblank_stb),
        .xfer    (xfer),
        .pending (pending)
    );

    cfg_bank #(
        .DATA_W  (DATA_W),
        .NUM_CFG (NUM_CFG)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wsel.cfg),
        .wr_idx  (cfg_idx),
        .wr_data (bus_wdata),
        .xfer    (xfer),
        .shadow  (shadow),
        .active  (active_cfg)
    );

    irq_gather #(
        .NEV (NUM_EV)
    ) u_irq (
        .clk      (clk),
        .rst      (rst),
        .en_we    (wsel.irq_en),
        .en_wdata (bus_wdata[NUM_EV-1:0]),
        .clr_we   (wsel.irq_clr),
        .clr_mask (bus_wdata[NUM_EV-1:0]),
        .events   (events),
        .status   (status),
        .enable   (enable),
        .irq      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel.reload) begin
            bus_rdata[1] = pending;
        end else if (sel.irq_en) begin
            bus_rdata[NUM_EV-1:0] = enable;
        end else if (sel.irq_clr) begin
            bus_rdata = '0;
        end else if (int'(bus_addr) == A_IRQ_STAT) begin
            bus_rdata[NUM_EV-1:0] = status;
        end else if (sel.cfg) begin
            bus_rdata = shadow[int'(cfg_idx)*DATA_W +: DATA_W];
        end
    end

    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        xfer |=> status[EV_RELOAD]); // R6
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |-> !irq); // R10

endmodule

// File: tb/test_cfg_reload_irq_unit.sv
module test_cfg_reload_irq_unit;

    localparam int DW = 32;
    localparam int NC = 4;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          vblank_stb = 1'b0;
    logic          line_evt = 1'b0;
    logic          underrun_evt = 1'b0;
    logic          xfer_err_evt = 1'b0;
    logic [NC*DW-1:0] active_cfg;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [DW-1:0] m_shadow [NC];
    logic [DW-1:0] m_active [NC];
    logic          m_pend;
    logic [3:0]    m_status;
    logic [3:0]    m_en;

    always #5 clk = ~clk;

    cfg_reload_irq_unit #(.DATA_W(DW), .NUM_CFG(NC), .ADDR_W(AW)) i_cfg_reload_irq_unit (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vblank_stb(vblank_stb),
        .line_evt(line_evt), .underrun_evt(underrun_evt), .xfer_err_evt(xfer_err_evt),
        .active_cfg(active_cfg), .irq(irq)
    );

    task automatic expect_eq(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rd_model(input int a);
        logic [DW-1:0] v = '0;
        if (a == 0) v[1] = m_pend;
        else if (a == 1) v[3:0] = m_en;
        else if (a == 2) v[3:0] = m_status;
        else if (a >= 4 && a < 4 + NC) v = m_shadow[a-4];
        return v;
    endfunction

    task automatic rd_check(input int a, input string tag);
        bus_wr = 1'b0;
        bus_addr = AW'(a);
        #1;
        expect_eq(bus_rdata, rd_model(a), $sformatf("%s read addr %0d", tag, a));
    endtask

    // full observation at a negedge
    task automatic check_all(input string tag);
        for (int i = 0; i < NC; i++)
            expect_eq(active_cfg[i*DW +: DW], m_active[i], $sformatf("%s active word %0d", tag, i));
        expect_eq({31'b0, irq}, {31'b0, |(m_status & m_en)}, {tag, " irq"});
        rd_check(2, tag);
        rd_check(0, tag);
        rd_check(1, tag);
    endtask

    task automatic step(input logic wr, input int a, input logic [DW-1:0] wd,
                        input logic [2:0] ev, input logic vb, input string tag);
        logic imm, late, xf;
        logic [3:0] clr;
        bus_wr = wr; bus_addr = AW'(a); bus_wdata = wd;
        line_evt = ev[0]; underrun_evt = ev[1]; xfer_err_evt = ev[2];
        vblank_stb = vb;
        imm  = wr && a == 0 && wd[0];
        late = wr && a == 0 && wd[1] && !wd[0];
        xf   = imm || (vb && m_pend);
        clr  = (wr && a == 3) ? wd[3:0] : 4'h0;
        @(posedge clk);
        if (xf) for (int i = 0; i < NC; i++) m_active[i] = m_shadow[i];
        if (imm) m_pend = 1'b0;
        else if (late) m_pend = 1'b1;
        else if (vb) m_pend = 1'b0;
        if (wr && a >= 4 && a < 4 + NC) m_shadow[a-4] = wd;
        m_status = (m_status & ~clr) | {xf, ev};
        if (wr && a == 1) m_en = wd[3:0];
        @(negedge clk);
        bus_wr = 1'b0; vblank_stb = 1'b0;
        line_evt = 1'b0; underrun_evt = 1'b0; xfer_err_evt = 1'b0;
        check_all(tag);
    endtask

    initial begin
        int unsigned s;
        logic [DW-1:0] v;
        for (int i = 0; i < NC; i++) begin m_shadow[i] = '0; m_active[i] = '0; end
        m_pend = 0; m_status = 0; m_en = 0;
        s = $urandom(32'h5EED);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");
        for (int i = 0; i < NC; i++) rd_check(4 + i, "R1");

        // staging writes do not reach live copy
        for (int i = 0; i < NC; i++) step(1, 4 + i, 32'hA000_0000 + i, 3'b0, 0, "R2");
        for (int i = 0; i < NC; i++) rd_check(4 + i, "R2");

        // deferred write with strobe in same cycle stays pending
        step(1, 0, 32'h2, 3'b0, 1, "R4");
        expect_eq({31'b0, m_pend}, 32'h1, "R4 model pending");
        step(0, 2, 0, 3'b0, 0, "R4");
        step(0, 2, 0, 3'b0, 1, "R4");   // transfer here
        step(0, 2, 0, 3'b0, 1, "R4");   // no pending: nothing
        expect_eq(m_status, 4'h8, "R6 reload-done flag");

        // read status then write it back
        bus_addr = 2; #1; v = bus_rdata;
        step(1, 3, v, 3'b0, 0, "R8");
        expect_eq(m_status, 4'h0, "R8 cleared");

        // immediate reload
        step(1, 5, 32'h1234_5678, 3'b0, 0, "R2");
        step(1, 0, 32'h1, 3'b0, 0, "R3");
        step(1, 0, 32'h0, 3'b0, 0, "R3");

        // both bits, and immediate over a pending request
        step(1, 6, 32'hBEEF_0001, 3'b0, 0, "R5");
        step(1, 0, 32'h3, 3'b0, 0, "R5");
        step(1, 4, 32'hBEEF_0002, 3'b0, 0, "R5");
        step(0, 2, 0, 3'b0, 1, "R5");
        step(1, 0, 32'h2, 3'b0, 0, "R5");
        step(1, 0, 32'h1, 3'b0, 0, "R5");
        step(0, 2, 0, 3'b0, 1, "R5");
        step(1, 3, 32'hF, 3'b0, 0, "R8");

        // masked events recorded, then enabled
        step(0, 2, 0, 3'b001, 0, "R7");
        step(0, 2, 0, 3'b110, 0, "R7");
        step(1, 1, 32'h4, 3'b000, 0, "R10");
        step(1, 3, 32'h4, 3'b000, 0, "R10");
        step(1, 3, 32'h2, 3'b010, 0, "R9");
        step(1, 3, 32'h5, 3'b000, 0, "R8");

        // unmapped writes
        step(1, 12, 32'hFFFF_FFFF, 3'b0, 0, "R11");
        rd_check(12, "R11");
        rd_check(3, "R11");

        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic wr;
            int a;
            wr = ($urandom % 4) != 0;
            a  = ($urandom % 10 == 0) ? 8 + ($urandom % 8) : $urandom % 8;
            step(wr, a, (a == 0) ? DW'($urandom % 4) : DW'($urandom),
                 3'($urandom % 8 == 0 ? $urandom : 0), ($urandom % 6) == 0,
                 "R3,R4,R7,R8,R10 random");
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #1_500_000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule